// File: doc/BRIEF.md
# Controlled-Slip Receive Elastic Buffer

This block is a bit-serial elastic store for E1 frames of 256 bits. One side writes bits into it, strobed at the recovered line rate. The other side reads them out, strobed at the system rate. Both strobes are enables in a single clock domain. The store holds two frames (512 bits). When the read side drifts too close to the write side in either direction, the buffer makes a controlled slip of exactly one frame. A read side that is running fast repeats a frame. A read side that is running slow drops a frame. Because the slip is a whole frame, frame alignment is kept on the output.

On every accepted read strobe the block also captures a 12-bit phase word. This word gives the current write-to-read delay: a frame flag, a channel number and a bit number within the channel. Below these sits a 3-bit sub-bit count of clocks since the most recent write strobe. Two flags track slips. A toggle changes on every slip, and a direction flag records which kind of slip happened last.

The controller is a two-state machine. **ST_PRIME** is entered at reset. In this state writes fill the store and read strobes are ignored. The transition **PRIME→RUN** is taken on the clock after the stored count reaches 256 bits. **ST_RUN** is a terminal state. In it every read strobe is classified as one of three kinds: **SLIP_NONE** (a plain read), **SLIP_REPEAT** (the stored count is at or below the guard) or **SLIP_DROP** (the stored count is at or above 512 minus the guard).

Top module: `elastic_slip_buffer`

## Requirements
- R1: After reset, rd_bit, slip_tgl, slip_dir and phase_word are 0 and the block is in ST_PRIME. In ST_PRIME, read strobes change no output and consume no data. The block enters ST_RUN on the clock after the stored count reaches 256.
- R2: In ST_RUN, bits come out on rd_bit in the order they were written. rd_bit is registered: it changes on the clock edge that samples rd_en and holds between read strobes.
- R3: A read strobe in ST_RUN with a stored count ≤ GUARD (default 4) makes a repeat slip. The read position moves back 256 bits, so the stored count rises by 256 before the bit is read.
- R4: A read strobe in ST_RUN with a stored count ≥ 512 − GUARD makes a drop slip. The read position skips ahead 256 bits, so the stored count falls by 256 before the bit is read.
- R5: slip_tgl inverts exactly once for each slip, in either direction, and at no other time.
- R6: slip_dir becomes 1 on a repeat slip and 0 on a drop slip. It keeps its value when no slip occurs.
- R7: phase_word[11] is 1 when the delay captured at the last accepted read is 256 bits or more, and 0 otherwise. The delay is the stored count after any slip adjustment and before the bit is removed.
- R8: phase_word[10:6] holds the channel number (delay bits 7:3) and phase_word[5:3] holds the bit-within-channel number (delay bits 2:0) of that same delay.
- R9: phase_word[2:0] holds the number of clocks between the most recent write strobe and the read strobe, saturating at 7. A write strobe clears the count on the following clock. With eight clocks per line bit, this is the sub-bit phase in eighths of a bit.
- R10: A write strobe that arrives while 512 bits are stored, with no accepted read in the same cycle, is discarded. The stored count never exceeds 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one per received bit |
| wr_bit | input | 1 | Received bit to store |
| rd_en | input | 1 | Read strobe, one per system-side bit |
| rd_bit | output | 1 | Registered output bit |
| slip_tgl | output | 1 | Inverts on every controlled slip |
| slip_dir | output | 1 | 1 = last slip repeated a frame, 0 = dropped a frame |
| phase_word | output | 12 | {frame flag, channel[4:0], bit[2:0], sub-bit[2:0]} |

## Verification
The hardest situation to reach from the ports is a slip. The stored count has to drift more than 250 bits away from the centre, which only a sustained rate mismatch can do. The stimulus therefore runs long phases of mismatched strobe periods: reads every 7 clocks against writes every 8, and then reads every 9 against writes every 8. These phases push the count down into the repeat guard and then up into the drop guard. A write-only burst fills the store completely to exercise discarded writes and a drop taken from a full store. A behavioural queue model in the bench tracks every bit, slip and phase field, and is compared on every clock.

// File: rtl/esb_pkg.sv
package esb_pkg;

    typedef enum logic {
        ST_PRIME = 1'b0,
        ST_RUN   = 1'b1
    } esb_state_t;

    typedef enum logic [1:0] {
        SLIP_NONE   = 2'd0,
        SLIP_REPEAT = 2'd1,
        SLIP_DROP   = 2'd2
    } slip_kind_t;

endpackage

// File: rtl/esb_store.sv
module esb_store #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_acc,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_data
);

    logic [DEPTH-1:0] mem_q;

    always_ff @(posedge clk) begin
        if (wr_acc) begin
            mem_q[wr_addr] <= wr_bit;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/esb_ctrl.sv
module esb_ctrl
    import esb_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int GUARD      = 4,
    localparam int DEPTH = 2 * FRAME_BITS,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          rd_data,
    output logic          wr_acc,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          rd_fire,
    output logic [AW-1:0] lvl_eff,
    output logic          rd_bit,
    output logic          slip_tgl,
    output logic          slip_dir
);

    esb_state_t state_q, state_d;
    slip_kind_t kind;
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [LW-1:0] level_q, level_d, lvl_full;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRIME;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: PRIME -> RUN once half the store is filled
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: if (level_q >= LW'(FRAME_BITS)) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_PRIME;
        endcase
    end

    // Read classification and slip arithmetic
    always_comb begin
        rd_fire = rd_en && (state_q == ST_RUN);
        kind    = SLIP_NONE;
        if (rd_fire) begin
            if (level_q <= LW'(GUARD)) begin
                kind = SLIP_REPEAT;
            end else if (level_q >= LW'(DEPTH - GUARD)) begin
                kind = SLIP_DROP;
            end
        end
        unique case (kind)
            SLIP_REPEAT: lvl_full = level_q + LW'(FRAME_BITS);
            SLIP_DROP:   lvl_full = level_q - LW'(FRAME_BITS);
            default:     lvl_full = level_q;
        endcase
        rd_addr = (kind == SLIP_NONE) ? rd_ptr_q : rd_ptr_q + AW'(FRAME_BITS);
        wr_acc  = wr_en && ((level_q != LW'(DEPTH)) || rd_fire);
        level_d = lvl_full - LW'(rd_fire) + LW'(wr_acc);
    end

    assign lvl_eff = lvl_full[AW-1:0];
    assign wr_addr = wr_ptr_q;

    // Pointers and fill level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else begin
            if (wr_acc)  wr_ptr_q <= wr_ptr_q + 1'b1;
            if (rd_fire) rd_ptr_q <= rd_addr + 1'b1;
            level_q <= level_d;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_bit   <= 1'b0;
            slip_tgl <= 1'b0;
            slip_dir <= 1'b0;
        end else if (rd_fire) begin
            rd_bit <= rd_data;
            if (kind != SLIP_NONE) begin
                slip_tgl <= ~slip_tgl;
                slip_dir <= (kind == SLIP_REPEAT);
            end
        end
    end

    p_level_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= LW'(DEPTH));

    p_prime_still_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRIME) |=> $stable(rd_ptr_q));

    p_eff_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |-> (lvl_full < LW'(DEPTH)));

    p_repeat_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SLIP_REPEAT) |=> slip_dir);

    p_drop_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SLIP_DROP) |=> !slip_dir);

endmodule

// File: rtl/esb_phase.sv
module esb_phase #(
    parameter int AW    = 9,
    parameter int SUB_W = 3,
    localparam int PW = AW + SUB_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_fire,
    input  logic [AW-1:0] lvl_eff,
    output logic [PW-1:0] phase_word
);

    localparam logic [SUB_W-1:0] FMAX = {SUB_W{1'b1}};

    logic [SUB_W-1:0] frac_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frac_q <= '0;
        end else if (wr_en) begin
            frac_q <= '0;
        end else if (frac_q != FMAX) begin
            frac_q <= frac_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_word <= '0;
        end else if (rd_fire) begin
            phase_word <= {lvl_eff, frac_q};
        end
    end

    p_frac_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (frac_q == '0));

    p_phase_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire |=> $stable(phase_word));

endmodule

// File: rtl/elastic_slip_buffer.sv
module elastic_slip_buffer #(
    parameter int FRAME_BITS = 256,
    parameter int GUARD      = 4,
    parameter int SUB_W      = 3,
    localparam int DEPTH = 2 * FRAME_BITS,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + SUB_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_bit,
    input  logic          rd_en,
    output logic          rd_bit,
    output logic          slip_tgl,
    output logic          slip_dir,
    output logic [PW-1:0] phase_word
);

    logic          wr_acc, rd_fire, rd_data;
    logic [AW-1:0] wr_addr, rd_addr, lvl_eff;

    esb_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_acc  (wr_acc),
        .wr_addr (wr_addr),
        .wr_bit  (wr_bit),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    esb_ctrl #(.FRAME_BITS(FRAME_BITS), .GUARD(GUARD)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .wr_acc   (wr_acc),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr),
        .rd_fire  (rd_fire),
        .lvl_eff  (lvl_eff),
        .rd_bit   (rd_bit),
        .slip_tgl (slip_tgl),
        .slip_dir (slip_dir)
    );

    esb_phase #(.AW(AW), .SUB_W(SUB_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_fire    (rd_fire),
        .lvl_eff    (lvl_eff),
        .phase_word (phase_word)
    );

    p_tgl_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slip_tgl) |-> $past(rd_en));

    p_dir_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(slip_tgl) |-> $stable(slip_dir));

    p_repeat_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(slip_tgl) && slip_dir) |-> phase_word[PW-1]);

endmodule

// File: tb/elastic_slip_buffer_test.sv
module elastic_slip_buffer_test;

    localparam int GUARD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic wr_bit = 1'b0;
    logic rd_en = 1'b0;
    logic rd_bit, slip_tgl, slip_dir;
    logic [11:0] phase_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    int m_mem [512];
    int m_wp = 0, m_rp = 0, m_lvl = 0, m_st = 0, m_frac = 0;
    int m_out = 0, m_tgl = 0, m_dir = 0, m_phase = 0;

    always #4 clk = ~clk;

    elastic_slip_buffer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit), .rd_en(rd_en),
        .rd_bit(rd_bit), .slip_tgl(slip_tgl), .slip_dir(slip_dir), .phase_word(phase_word)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(input int w, input int b, input int r);
        int fire, nst, l, p, kind, acc;
        fire = (r != 0 && m_st == 1) ? 1 : 0;
        nst  = (m_st == 0 && m_lvl >= 256) ? 1 : m_st;
        l = m_lvl; p = m_rp; kind = 0;
        if (fire != 0) begin
            if (m_lvl <= GUARD) begin kind = 1; l = l + 256; p = (p + 256) % 512; end
            else if (m_lvl >= 512 - GUARD) begin kind = 2; l = l - 256; p = (p + 256) % 512; end
        end
        acc = (w != 0 && (m_lvl < 512 || fire != 0)) ? 1 : 0;
        if (fire != 0) begin
            m_out = m_mem[p];
            m_phase = (l << 3) | m_frac;
            m_rp = (p + 1) % 512;
            if (kind != 0) begin m_tgl = 1 - m_tgl; m_dir = (kind == 1) ? 1 : 0; end
        end
        if (acc != 0) begin m_mem[m_wp] = b; m_wp = (m_wp + 1) % 512; end
        m_lvl = l - fire + acc;
        m_frac = (w != 0) ? 0 : ((m_frac < 7) ? m_frac + 1 : 7);
        m_st = nst;
    endtask

    task automatic compare_all();
        chk("R2 rd_bit", int'(rd_bit), m_out);
        chk("R5 slip_tgl", int'(slip_tgl), m_tgl);
        chk("R6 slip_dir", int'(slip_dir), m_dir);
        chk("R7 frame flag", int'(phase_word[11]), (m_phase >> 11) & 1);
        chk("R8 channel/bit", int'(phase_word[10:3]), (m_phase >> 3) & 255);
        chk("R9 sub-bit", int'(phase_word[2:0]), m_phase & 7);
    endtask

    task automatic cyc(input logic w, input logic r);
        logic b;
        b = 1'($urandom);
        wr_en = w; wr_bit = b; rd_en = r;
        @(posedge clk);
        model_step(int'(w), int'(b), int'(r));
        @(negedge clk);
        compare_all();
    endtask

    task automatic run_rates(input int cycles, input int wper, input int rper, input int roff);
        for (int i = 0; i < cycles; i++) begin
            cyc(logic'((i % wper) == 0), logic'(((i + roff) % rper) == 0));
        end
    endtask

    initial begin
        int tgl_before;
        for (int i = 0; i < 512; i++) m_mem[i] = 0;
        repeat (5) @(negedge clk);
        // R1: reset values
        chk("R1 reset rd_bit", int'(rd_bit), 0);
        chk("R1 reset slip_tgl", int'(slip_tgl), 0);
        chk("R1 reset slip_dir", int'(slip_dir), 0);
        chk("R1 reset phase", int'(phase_word), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: priming, reads ignored
        run_rates(800, 8, 8, 3);
        chk("R1 prime rd_bit", int'(rd_bit), 0);
        chk("R1 prime phase", int'(phase_word), 0);
        run_rates(1300, 8, 8, 3);

        // balanced operation
        run_rates(4000, 8, 8, 5);

        // R3: fast reads drain to repeat slip
        tgl_before = int'(slip_tgl);
        run_rates(20000, 8, 7, 2);
        chk("R3 repeat slip dir", int'(slip_dir), 1);
        chk("R5 toggled on repeat", int'(slip_tgl), 1 - tgl_before);

        // R4: slow reads fill to drop slip
        tgl_before = int'(slip_tgl);
        run_rates(32000, 8, 9, 4);
        chk("R4 drop slip dir", int'(slip_dir), 0);
        chk("R5 toggled on drop", int'(slip_tgl), 1 - tgl_before);

        // R10: overfill with writes only, then one read
        run_rates(600, 1, 1000000, 1);
        cyc(1'b0, 1'b1);
        chk("R10 full-store delay", int'(phase_word), 12'h800);
        chk("R10 drop from full dir", int'(slip_dir), 0);

        // mixed random strobes
        for (int i = 0; i < 4000; i++) begin
            cyc(logic'(($urandom % 8) < 3), logic'(($urandom % 8) < 3));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule